// File: doc/BRIEF.md
# DMA Request Line to Channel Router

This block sits between a set of peripheral DMA request lines and the channels of a DMA engine. Software fills a table with one small map entry per request line. Each entry says whether the line is in use and which channel it feeds. Every cycle the block combines the live request lines through that table into one request level per channel. It also marks the cycles in which a channel's level starts or stops.

The start marker tells the engine that a peripheral has begun asking for service. The stop marker tells it that a receiving peripheral has run out of data and the current burst has ended. The table sits in two separate windows of a 32-bit register space. Entries for the first 64 lines occupy one window and the remaining lines occupy a second window higher up.

Each entry can be read back. A write that points a valid entry at a channel the engine does not have raises an error strobe.

Top module: `dma_req_router`

## Requirements
- R1: After reset all map entries read as 0, which marks them unused, and all channel levels, start markers, stop markers and the error strobe are 0.
- R2: A write to offset 0x100 + 4*n (n from 0 to 63) stores bits 7:0 of the data as entry n. A read of that offset returns the stored byte in bits 7:0 with bits 31:8 zero, on the cycle after the read strobe.
- R3: Entries 64 and up (74 by default) are written and read the same way at offset 0x1100 + 4*(n-64).
- R4: An entry is used only when its bit 7 is 1. A request line whose entry has bit 7 at 0 drives no channel level and causes no marker.
- R5: Bits 4:0 of a used entry select the channel. A channel's level is the OR of all request lines whose used entries select it, and it is registered one cycle after the inputs or the table change.
- R6: When a channel level goes from 0 to 1, that channel's start marker is 1 for exactly one cycle, aligned with the first cycle of high level. A line that joins a channel already held high by another line gives no start marker.
- R7: When a channel level goes from 1 to 0, that channel's stop marker is 1 for exactly one cycle, aligned with the first cycle of low level. A channel held high by a second line gives no stop marker when one line drops.
- R8: A write of a used entry whose channel field is not below the channel count pulses the error strobe for one cycle after the write. The entry is still stored and reads back as written, and its request line drives no channel.
- R9: Writes to offsets outside both windows, including 0x100 + 4*n or 0x1100 + 4*k beyond the last entry and offsets not on a word boundary, change no entry. Reads of those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| map_err | output | 1 | One-cycle strobe after a write selecting a missing channel |
| dreq | input | NUM_REQ | Peripheral request lines |
| chan_req | output | NUM_CH | Registered request level per channel |
| chan_ras | output | NUM_CH | Start marker per channel, one cycle |
| chan_eor | output | NUM_CH | Stop marker per channel, one cycle |

## Verification
A wrong table entry shows up as a channel level on the wrong bit, or a missing level. It becomes visible one cycle after the request line moves, and at read-back one cycle after the read. A stuck or stale channel level register shows up as a missing or repeated start or stop marker at the next edge of the request line. Decode faults in either window show up as read-back mismatches or as stray stores, which are found by sweeping every entry and the offsets just past both windows.

// File: rtl/dmarm_pkg.sv
package dmarm_pkg;
  localparam int ENTRY_W   = 8;
  localparam int CHSEL_W   = 5;
  localparam int VALID_BIT = 7;
  localparam int HI_BASE   = 64;

  typedef struct packed {
    logic               valid;
    logic [1:0]         spare;
    logic [CHSEL_W-1:0] chan;
  } map_entry_t;
endpackage

// File: rtl/dmarm_map_table.sv
module dmarm_map_table
  import dmarm_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 32,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic                            map_err,
  output logic [NUM_REQ-1:0][ENTRY_W-1:0] entries
);
  localparam int LO_CNT = (NUM_REQ < HI_BASE) ? NUM_REQ : HI_BASE;
  localparam int HI_CNT = NUM_REQ - LO_CNT;
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam logic [ADDR_W-9:0] LO_PAGE = (ADDR_W-8)'(8'h01);
  localparam logic [ADDR_W-9:0] HI_PAGE = (ADDR_W-8)'(8'h11);

  logic [ENTRY_W-1:0] tbl [NUM_REQ];
  logic               hit;
  logic [IDX_W-1:0]   idx;
  logic [5:0]         word;
  logic [ADDR_W-9:0]  page;

  assign word = addr[7:2];
  assign page = addr[ADDR_W-1:8];

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (addr[1:0] == 2'b00) begin
      if (page == LO_PAGE && int'(word) < LO_CNT) begin
        hit = 1'b1;
        idx = IDX_W'(word);
      end else if (page == HI_PAGE && int'(word) < HI_CNT) begin
        hit = 1'b1;
        idx = IDX_W'(word) + IDX_W'(HI_BASE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REQ; i++) tbl[i] <= '0;
    end else if (wr_en && hit) begin
      tbl[idx] <= wdata[ENTRY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= hit ? DATA_W'(tbl[idx]) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) map_err <= 1'b0;
    else     map_err <= wr_en && hit && wdata[VALID_BIT]
                        && (int'(wdata[CHSEL_W-1:0]) >= NUM_CH);
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_out
    assign entries[i] = tbl[i];
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:ENTRY_W];

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    map_err |-> $past(wr_en)); // R8
endmodule

// File: rtl/dmarm_crossbar.sv
module dmarm_crossbar
  import dmarm_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 32
) (
  input  logic [NUM_REQ-1:0][ENTRY_W-1:0] entries,
  input  logic [NUM_REQ-1:0]              dreq,
  output logic [NUM_CH-1:0]               level_nxt
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      map_entry_t e;
      level_nxt[c] = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        e = map_entry_t'(entries[r]);
        if (e.valid && e.chan == CHSEL_W'(c) && dreq[r]) level_nxt[c] = 1'b1;
      end
    end
  end

  logic unused_spare;
  always_comb begin
    unused_spare = 1'b0;
    for (int r = 0; r < NUM_REQ; r++)
      unused_spare = unused_spare ^ (^entries[r][6:5]);
  end
endmodule

// File: rtl/dmarm_chan_events.sv
module dmarm_chan_events #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] level_nxt,
  output logic [NUM_CH-1:0] level_q,
  output logic [NUM_CH-1:0] ras_q,
  output logic [NUM_CH-1:0] eor_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        level_q[c] <= 1'b0;
        ras_q[c]   <= 1'b0;
        eor_q[c]   <= 1'b0;
      end else begin
        level_q[c] <= level_nxt[c];
        ras_q[c]   <= level_nxt[c] && !level_q[c];
        eor_q[c]   <= !level_nxt[c] && level_q[c];
      end
    end

    AST_RAS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
      ras_q[c] |-> (level_q[c] && !$past(level_q[c]))); // R6
    AST_EOR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
      eor_q[c] |-> (!level_q[c] && $past(level_q[c]))); // R7
    AST_CHANGE_MARKED: assert property (@(posedge clk) disable iff (rst)
      (level_q[c] != $past(level_q[c])) |-> (ras_q[c] || eor_q[c])); // R5
  end
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmarm_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 32,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               map_err,
  input  logic [NUM_REQ-1:0] dreq,
  output logic [NUM_CH-1:0]  chan_req,
  output logic [NUM_CH-1:0]  chan_ras,
  output logic [NUM_CH-1:0]  chan_eor
);
  logic [NUM_REQ-1:0][ENTRY_W-1:0] entries;
  logic [NUM_CH-1:0]               level_nxt;

  dmarm_map_table #(
    .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_table (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .map_err(map_err), .entries(entries)
  );

  dmarm_crossbar #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_xbar (
    .entries(entries), .dreq(dreq), .level_nxt(level_nxt)
  );

  dmarm_chan_events #(.NUM_CH(NUM_CH)) u_events (
    .clk(clk), .rst(rst), .level_nxt(level_nxt),
    .level_q(chan_req), .ras_q(chan_ras), .eor_q(chan_eor)
  );
endmodule

// File: tb/tb_dma_req_router.sv
module tb_dma_req_router;
  localparam int CLK_P = 10;
  localparam int NREQ  = 75;
  localparam int NCH   = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [15:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            map_err;
  logic [NREQ-1:0] dreq = '0;
  logic [NCH-1:0]  chan_req, chan_ras, chan_eor;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dma_req_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .map_err(map_err), .dreq(dreq),
    .chan_req(chan_req), .chan_ras(chan_ras), .chan_eor(chan_eor)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] addr_of(int n);
    if (n < 64) return 16'(32'h100 + 4*n);
    return 16'(32'h1100 + 4*(n-64));
  endfunction

  task automatic wr(logic [15:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic chk_outs(string tag, int lvl, int ras, int eor);
    check({tag, " level"}, 32'(chan_req), 32'(lvl));
    check({tag, " start"}, 32'(chan_ras), 32'(ras));
    check({tag, " stop"},  32'(chan_eor), 32'(eor));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_outs("R1 reset", 0, 0, 0);
    check("R1 reset err", 32'(map_err), 0);
    for (int n = 0; n < NREQ; n++) begin
      rd(addr_of(n), d);
      check(n < 64 ? "R1 reset entry lo" : "R1 reset entry hi", d, 0);
    end

    // R2 / R3: write a computed pattern to every entry, then read all back
    for (int n = 0; n < NREQ; n++) begin
      logic [7:0] p;
      p = 8'((n*37 + 5) & 8'hFF);
      wr(addr_of(n), {24'hABCDEF, p});
      check("R8 err on pattern write", 32'(map_err),
            32'(p[7] && (int'(p[4:0]) >= NCH)));
    end
    for (int n = 0; n < NREQ; n++) begin
      rd(addr_of(n), d);
      check(n < 64 ? "R2 readback" : "R3 readback", d, 32'((n*37 + 5) & 8'hFF));
    end
    for (int n = 0; n < NREQ; n++) wr(addr_of(n), 0);

    // R9: offsets outside both windows
    wr(16'h112C, 32'hFF); rd(16'h112C, d); check("R9 past hi window", d, 0);
    wr(16'h0200, 32'h81); rd(16'h0200, d); check("R9 past lo window", d, 0);
    wr(16'h0102, 32'h83); rd(16'h0100, d); check("R9 unaligned lo", d, 0);
    wr(16'h1101, 32'h84); rd(16'h1100, d); check("R9 unaligned hi", d, 0);
    rd(16'h0102, d); check("R9 unaligned read", d, 0);

    // R5/R6/R7: each line to its own channel, rise and fall
    for (int n = 0; n < NREQ; n++) begin
      int m;
      m = 1 << (n % NCH);
      wr(addr_of(n), 32'h80 | 32'(n % NCH));
      dreq[n] = 1'b1;
      @(negedge clk); chk_outs("R5 R6 rise", m, m, 0);
      @(negedge clk); chk_outs("R6 hold", m, 0, 0);
      dreq[n] = 1'b0;
      @(negedge clk); chk_outs("R7 fall", 0, 0, m);
      @(negedge clk); chk_outs("R7 after", 0, 0, 0);
      wr(addr_of(n), 0);
    end

    // R4: unused entries are ignored
    for (int n = 0; n < NREQ; n++) begin
      wr(addr_of(n), 32'(n % NCH) | 32'h60);
      dreq[n] = 1'b1;
      @(negedge clk); chk_outs("R4 unused rise", 0, 0, 0);
      dreq[n] = 1'b0;
      @(negedge clk); chk_outs("R4 unused fall", 0, 0, 0);
      wr(addr_of(n), 0);
    end

    // R5/R6/R7: two lines sharing channel 5
    wr(addr_of(3), 32'h85); wr(addr_of(70), 32'h85);
    dreq[3] = 1'b1;  @(negedge clk); chk_outs("R6 share first", 32, 32, 0);
    dreq[70] = 1'b1; @(negedge clk); chk_outs("R6 share join", 32, 0, 0);
    dreq[3] = 1'b0;  @(negedge clk); chk_outs("R7 share one drop", 32, 0, 0);
    dreq[70] = 1'b0; @(negedge clk); chk_outs("R7 share last drop", 0, 0, 32);
    wr(addr_of(3), 0); wr(addr_of(70), 0);

    // R5: remap a live line from channel 2 to channel 7
    wr(addr_of(20), 32'h82);
    dreq[20] = 1'b1; @(negedge clk); chk_outs("R5 remap before", 4, 4, 0);
    wr(addr_of(20), 32'h87);
    @(negedge clk); chk_outs("R5 remap after", 128, 128, 4);
    dreq[20] = 1'b0; wr(addr_of(20), 0);
    @(negedge clk);

    // R8: channel beyond the count
    wr(addr_of(10), 32'h8E);
    check("R8 err pulse", 32'(map_err), 1);
    @(negedge clk); check("R8 err one cycle", 32'(map_err), 0);
    dreq[10] = 1'b1; @(negedge clk); chk_outs("R8 missing channel", 0, 0, 0);
    dreq[10] = 1'b0;
    rd(addr_of(10), d); check("R8 stored", d, 32'h8E);
    wr(addr_of(10), 32'h0E);
    check("R8 unused no err", 32'(map_err), 0);
    wr(addr_of(11), 32'h80 | 32'(NCH-1));
    check("R8 top channel no err", 32'(map_err), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule